// File: doc/BRIEF.md
# Parallel-Load Pixel Serializer

This block turns words read from display memory into a stream of single-bit pixels. It runs on the pixel clock, which is the fastest clock in the display path. A parallel-in, serial-out register takes in one memory word and then sends it out one bit per clock. Because each word carries eight pixels, the word address only has to move at one eighth of the pixel rate. The memory therefore only has to supply one word every eight pixel clocks.

The raster timing logic drives two inputs: an active-video flag and a frame-start pulse. While active video is high, the block raises a load strobe at each word boundary. At that clock edge it captures the word present on the data input and advances its own word address, which the memory uses for the next fetch. Each pixel appears on the serial output one clock after the active-video cycle it belongs to. The output is held at zero outside active video.

Top module: `pixel_serializer`

## Requirements
- R1: While reset is high and on the first cycle after it, pix_out, load_stb and word_addr are all zero.
- R2: load_stb is high in the first cycle of each run of consecutive active cycles and in every eighth active cycle after that. It is never high in a cycle where active is low.
- R3: On a clock edge where load_stb is high, mem_data is captured. Its bit 7 appears on pix_out in the next cycle, followed by bits 6 down to 0 on the seven cycles after that.
- R4: Within an unbroken active run, the next word loads on the ninth active cycle. Its bit 7 therefore follows bit 0 of the previous word with no idle cycle between them.
- R5: word_addr increases by one at each clock edge where load_stb is high and holds at all other edges. It wraps from 2^ADDR_W-1 to 0.
- R6: A frame_start cycle sets word_addr to 0 and restarts the word phase. It wins over a load that would fall in the same cycle: load_stb stays low in that cycle and pix_out is 0 in the next one.
- R7: pix_out is 0 in every cycle that follows a cycle in which active was low.
- R8: When active falls partway through a word, the rest of that word is dropped. The next active run loads a new word from the current word_addr, which is the address after the dropped word's address, and does not fetch the dropped word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that restarts addressing for a new frame |
| active | input | 1 | Active-video flag from the raster timing logic |
| mem_data | input | WORD_W | Word read from memory at word_addr |
| pix_out | output | 1 | Serial pixel, bit 7 of each word first |
| word_addr | output | ADDR_W | Address of the word to fetch |
| load_stb | output | 1 | High in the cycle whose closing edge captures mem_data |

## Verification
Memory contents are derived from the address, so each word has a different bit pattern. A word fetched from the wrong address, or in the wrong bit order, shows up as a pixel mismatch. Runs whose length is a multiple of eight separate gapless reloading from late or early loads. A 13-cycle run cuts a word short, which separates dropping the tail of the word from stalling or fetching it again. A frame-start pulse during blanking and another in the middle of a run check address clearing and its priority over a load. A run longer than the address space, with a reduced address width, checks wrap-around.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    // Action applied to the shift register in a given cycle
    typedef enum logic [1:0] {
        SR_HOLD  = 2'd0,
        SR_LOAD  = 2'd1,
        SR_SHIFT = 2'd2,
        SR_CLEAR = 2'd3
    } sr_op_e;

    // Decide the register action from frame start, active video and word boundary
    function automatic sr_op_e pick_op(input logic fs, input logic act, input logic boundary);
        sr_op_e op;
        if (fs)
            op = SR_CLEAR;
        else if (!act)
            op = SR_HOLD;
        else if (boundary)
            op = SR_LOAD;
        else
            op = SR_SHIFT;
        return op;
    endfunction

endpackage

// File: rtl/pxser_phase.sv
module pxser_phase #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fs,
    input  logic active,
    output logic boundary
);
    localparam int PH_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || fs || !active)
            phase <= '0;
        else if (phase == PH_LAST)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign boundary = (phase == '0);
endmodule

// File: rtl/pxser_addr.sv
module pxser_addr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst || fs)
            addr <= '0;
        else if (adv)
            addr <= addr + 1'b1;
    end
endmodule

// File: rtl/pxser_piso.sv
module pxser_piso
    import pxser_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sr_op_e            op,
    input  logic [WORD_W-1:0] din,
    output logic              msb
);
    logic [WORD_W-1:0] sr;
    logic [WORD_W-1:0] shifted;

    generate
        if (WORD_W > 1) begin : g_wide
            assign shifted = {sr[WORD_W-2:0], 1'b0};
        end else begin : g_single
            assign shifted = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else begin
            unique case (op)
                SR_LOAD:  sr <= din;
                SR_SHIFT: sr <= shifted;
                SR_CLEAR: sr <= '0;
                default:  sr <= sr;
            endcase
        end
    end

    assign msb = sr[WORD_W-1];
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
    import pxser_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              active,
    input  logic [WORD_W-1:0] mem_data,
    output logic              pix_out,
    output logic [ADDR_W-1:0] word_addr,
    output logic              load_stb
);
    logic   boundary;
    logic   msb;
    logic   act_q;
    sr_op_e op;

    assign op       = pick_op(frame_start, active, boundary);
    assign load_stb = !rst && (op == SR_LOAD);

    pxser_phase #(.WORD_W(WORD_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .fs       (frame_start),
        .active   (active),
        .boundary (boundary)
    );

    pxser_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .fs   (frame_start),
        .adv  (load_stb),
        .addr (word_addr)
    );

    pxser_piso #(.WORD_W(WORD_W)) u_piso (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .din (mem_data),
        .msb (msb)
    );

    // Pixel stage: gate with active video delayed to line up with the shifter
    always_ff @(posedge clk) begin
        if (rst)
            act_q <= 1'b0;
        else
            act_q <= active;
    end

    assign pix_out = act_q & msb;
endmodule

// File: rtl/pixel_serializer_chk.sv
module pixel_serializer_chk #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              active,
    input logic [WORD_W-1:0] mem_data,
    input logic              pix_out,
    input logic [ADDR_W-1:0] word_addr,
    input logic              load_stb
);
    // R2
    stb_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> active);

    // R2
    stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> !load_stb);

    // R3
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (pix_out == $past(mem_data[WORD_W-1])));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (load_stb && !frame_start) |=> (word_addr == $past(word_addr) + 1'b1));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_stb && !frame_start) |=> $stable(word_addr));

    // R6
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (word_addr == '0 && pix_out == 1'b0));

    // R6
    frame_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !load_stb);

    // R7
    blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !pix_out);
endmodule

bind pixel_serializer pixel_serializer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .active      (active),
    .mem_data    (mem_data),
    .pix_out     (pix_out),
    .word_addr   (word_addr),
    .load_stb    (load_stb)
);

// File: tb/test_pixel_serializer.sv
`timescale 1ns/1ps
module test_pixel_serializer;
    localparam int WORD_W = 8;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic              active = 1'b0;
    logic [WORD_W-1:0] mem_data;
    logic              pix_out;
    logic [ADDR_W-1:0] word_addr;
    logic              load_stb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        logic [WORD_W-1:0] w;
        w = WORD_W'(a) * 8'h1D;
        return w ^ 8'hA5 ^ {a[1:0], 6'b0};
    endfunction

    assign mem_data = mem_word(word_addr);

    pixel_serializer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_pixel_serializer (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .active      (active),
        .mem_data    (mem_data),
        .pix_out     (pix_out),
        .word_addr   (word_addr),
        .load_stb    (load_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard state, owned by the monitor
    logic             exp_q[$];
    logic [ADDR_W-1:0] exp_addr = '0;
    int               run_pos = 0;
    bit               prev_act = 0;
    bit               mon_en = 0;

    // Driver tasks: drive inputs 1 ns after the rising edge
    task automatic drive_run(input int n, input int fs_at);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            active = 1'b1;
            frame_start = (i == fs_at);
        end
    endtask

    task automatic drive_idle(input int n, input bit fs_first);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            active = 1'b0;
            frame_start = fs_first && (i == 0);
        end
    endtask

    // Monitor: samples at the falling edge, pushes expected pixels on loads
    always @(negedge clk) begin
        if (mon_en && !finished) begin
            bit exp_load;
            logic exp_pix;
            // R3 R4 R7: pixel produced for the previous cycle
            if (prev_act) begin
                exp_pix = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
                check(pix_out == exp_pix, "R3 R4 pixel", int'(pix_out), int'(exp_pix));
            end else begin
                check(pix_out == 1'b0, "R7 blank pixel", int'(pix_out), 0);
            end
            if (!active || frame_start) exp_q.delete();
            exp_load = active && !frame_start && (run_pos % WORD_W == 0);
            // R2 R6: strobe placement
            check(load_stb == exp_load, "R2 R6 load_stb", int'(load_stb), int'(exp_load));
            // R5 R8: address
            check(word_addr == exp_addr, "R5 R8 word_addr", int'(word_addr), int'(exp_addr));
            if (exp_load) begin
                for (int b = WORD_W - 1; b >= 0; b--) exp_q.push_back(mem_word(exp_addr)[b]);
            end
            if (frame_start) begin
                exp_addr = '0;
                run_pos = 0;
            end else if (active) begin
                if (exp_load) exp_addr = exp_addr + 1'b1;
                run_pos++;
            end else begin
                run_pos = 0;
            end
            prev_act = active && !frame_start;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(pix_out == 1'b0 && load_stb == 1'b0 && word_addr == '0, "R1 reset",
              int'({pix_out, load_stb}) + int'(word_addr), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(pix_out == 1'b0 && load_stb == 1'b0 && word_addr == '0, "R1 after reset",
              int'({pix_out, load_stb}) + int'(word_addr), 0);
        mon_en = 1;

        // R2 R3 R4: five back-to-back words
        drive_run(40, -1);
        drive_idle(10, 0);
        @(negedge clk);
        check(word_addr == 6'd5, "R4 five words", int'(word_addr), 5);

        // R8: run cut partway through the second word
        drive_run(13, -1);
        drive_idle(6, 0);
        @(negedge clk);
        check(word_addr == 6'd7, "R8 after cut run", int'(word_addr), 7);
        drive_run(8, -1);
        drive_idle(4, 0);
        @(negedge clk);
        check(word_addr == 6'd8, "R8 resume at next word", int'(word_addr), 8);

        // R6: frame start in blanking, then in the middle of a run
        drive_idle(3, 1);
        @(negedge clk);
        check(word_addr == '0, "R6 frame clears address", int'(word_addr), 0);
        drive_run(16, -1);
        drive_run(20, 8);
        drive_idle(5, 0);

        // R5: wrap past the top of the address space
        drive_idle(2, 1);
        drive_run((1 << ADDR_W) * WORD_W + 24, -1);
        drive_idle(4, 0);
        @(negedge clk);
        check(word_addr == 6'd3, "R5 wrap", int'(word_addr), 3);

        drive_idle(4, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule